// File: doc/BRIEF.md
# Write Protection Command Sequencer

This block sits beside the page-write controller of a byte-wide nonvolatile memory and decides, write by write, whether a latched write may reach the array. It watches every write strobe with its address and data. It recognises two fixed command codes. A three-write code turns protection on and opens one page-load window. A six-write code turns protection off. A protect flag models the nonvolatile state. A power-on reset leaves this flag alone. A separate initialisation reset puts it in the state the part has when new, which is unprotected.

While unprotected, every write is allowed, including the command writes themselves, and chip erase is allowed. While protected, chip erase is refused and data writes are refused. The one exception is the page load that directly follows the three-write code, and its bytes must all fall in one page. A write that breaks a partly entered code sends the detector back to idle. The page-write controller reports the end of a page load with a strobe, and that strobe closes the window.

Top module: `wp_seq_top`

## Requirements
- R1: After the initialisation reset the block is unprotected: `protOn` is 0, every write gives `wrAllow`=1 and `eraseReq` gives `eraseAllow`=1.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h set `protOn` at the clock edge of the third write. When this code is entered while unprotected, all three writes are allowed.
- R3: While protected and outside a page window, a data write gives `wrAllow`=0.
- R4: While `protOn` is 1, `eraseAllow` is 0 whatever `eraseReq` is. While `protOn` is 0, `eraseAllow` follows `eraseReq` in the same cycle.
- R5: After the three-write code, writes are allowed when their page number matches the page of the first write in the window. The page number is address bits [10:6]. A write in the window with a different page number gives `wrAllow`=0.
- R6: A `pageEnd` pulse closes the window. Later data writes are refused until the code is entered again.
- R7: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 20h@555h clear `protOn` at the edge of the sixth write. After that, writes are allowed.
- R8: A write that does not match the next expected step of a code returns the detector to idle. A later final code step on its own does not open a window.
- R9: The power-on reset `rstN` returns the detector to idle but leaves `protOn` unchanged.
- R10: While protected, the command writes themselves give `wrAllow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low; clears the detector only |
| nvInitN | input | 1 | Initialisation reset, active low; clears the protect flag |
| wrValid | input | 1 | One latched write this cycle |
| wrAddr | input | 11 | Write address |
| wrData | input | 8 | Write data |
| pageEnd | input | 1 | Page load finished (load timer expired) |
| eraseReq | input | 1 | Chip erase request |
| wrAllow | output | 1 | Current write may be committed |
| eraseAllow | output | 1 | Chip erase may proceed |
| protOn | output | 1 | Protect flag |

## Verification
A detector left in the wrong step shows up at the next write. A final code byte then either opens a window it should not, which is seen as `wrAllow`=1 on a data write one cycle later, or fails to open one. A flag that is lost or set by mistake shows on `protOn` and `eraseAllow` in the cycle after the edge that corrupted it. A stale window shows as an allowed write after `pageEnd`. The bench runs sequences that are broken partway, resets that arrive mid-code, and page changes inside a window. Each of these diverges from the expected allow value at its first following write.

// File: rtl/wp_seq_pkg.sv
`timescale 1ns/1ps
package wp_seq_pkg;
  localparam logic [10:0] KEY_ADDR_HI = 11'h555;
  localparam logic [10:0] KEY_ADDR_LO = 11'h2AA;
  localparam logic [7:0]  KEY_STEP1   = 8'hAA;
  localparam logic [7:0]  KEY_STEP2   = 8'h55;
  localparam logic [7:0]  KEY_SET     = 8'hA0;
  localparam logic [7:0]  KEY_DIS     = 8'h80;
  localparam logic [7:0]  KEY_CLR     = 8'h20;

  typedef enum logic [2:0] {
    SqIdle, SqA1, SqA2, SqD3, SqD4, SqD5, SqWin
  } seqState_t;

  typedef struct packed {
    logic k1;    // AAh at 555h
    logic k2;    // 55h at 2AAh
    logic kSet;  // A0h at 555h
    logic kDis;  // 80h at 555h
    logic kClr;  // 20h at 555h
  } keyHit_t;

  typedef struct packed {
    logic setProt;
    logic clrProt;
    logic winOpen;
  } ctlStrobe_t;
endpackage

// File: rtl/wp_seq_ctrl.sv
`timescale 1ns/1ps
module wp_seq_ctrl
  import wp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       pageEnd,
  input  keyHit_t    hit,
  output ctlStrobe_t ctl
);
  seqState_t state, stateNxt;
  logic setNxt, clrNxt;

  always_comb begin
    stateNxt = state;
    setNxt   = 1'b0;
    clrNxt   = 1'b0;
    if (wrValid) begin
      case (state)
        SqIdle: stateNxt = hit.k1 ? SqA1 : SqIdle;
        SqA1:   stateNxt = hit.k2 ? SqA2 : SqIdle;
        SqA2: begin
          if (hit.kSet) begin
            stateNxt = SqWin;
            setNxt   = 1'b1;
          end else if (hit.kDis) begin
            stateNxt = SqD3;
          end else begin
            stateNxt = SqIdle;
          end
        end
        SqD3:   stateNxt = hit.k1 ? SqD4 : SqIdle;
        SqD4:   stateNxt = hit.k2 ? SqD5 : SqIdle;
        SqD5: begin
          stateNxt = SqIdle;
          clrNxt   = hit.kClr;
        end
        SqWin:  stateNxt = SqWin;
        default: stateNxt = SqIdle;
      endcase
    end
    if (pageEnd && state == SqWin) stateNxt = SqIdle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SqIdle;
    else       state <= stateNxt;
  end

  always_comb begin
    ctl.setProt = setNxt;
    ctl.clrProt = clrNxt;
    ctl.winOpen = (state == SqWin);
  end

  // R2: a completed set code opens the page window on the next cycle
  a_r2_set_opens_window: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setProt |=> ctl.winOpen);

  // R6: page end closes an open window
  a_r6_end_closes: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.winOpen && pageEnd) |=> !ctl.winOpen);

  // R8: a broken second step falls back to idle, so no window follows
  a_r8_break_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == SqA1 && wrValid && !hit.k2) |=> (state == SqIdle));
endmodule

// File: rtl/wp_seq_dp.sv
`timescale 1ns/1ps
module wp_seq_dp
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int PAGE_LSB = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nvInitN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              eraseReq,
  input  ctlStrobe_t        ctl,
  output keyHit_t           hit,
  output logic              wrAllow,
  output logic              eraseAllow,
  output logic              protOn
);
  localparam int PAGE_W = ADDR_W - PAGE_LSB;

  logic              protFlag;
  logic              pageHeld;
  logic [PAGE_W-1:0] pageReg;
  logic [PAGE_W-1:0] pageCur;
  logic              atHi, atLo, pageHit;

  assign pageCur = wrAddr[ADDR_W-1:PAGE_LSB];
  assign atHi    = (wrAddr == ADDR_W'(KEY_ADDR_HI));
  assign atLo    = (wrAddr == ADDR_W'(KEY_ADDR_LO));

  always_comb begin
    hit.k1   = atHi && (wrData == DATA_W'(KEY_STEP1));
    hit.k2   = atLo && (wrData == DATA_W'(KEY_STEP2));
    hit.kSet = atHi && (wrData == DATA_W'(KEY_SET));
    hit.kDis = atHi && (wrData == DATA_W'(KEY_DIS));
    hit.kClr = atHi && (wrData == DATA_W'(KEY_CLR));
  end

  // nonvolatile protect flag: only the initialisation reset clears it
  always_ff @(posedge clk or negedge nvInitN) begin
    if (!nvInitN)         protFlag <= 1'b0;
    else if (ctl.setProt) protFlag <= 1'b1;
    else if (ctl.clrProt) protFlag <= 1'b0;
  end

  // page captured by the first write of a window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageHeld <= 1'b0;
      pageReg  <= '0;
    end else if (!ctl.winOpen) begin
      pageHeld <= 1'b0;
    end else if (wrValid && !pageHeld) begin
      pageHeld <= 1'b1;
      pageReg  <= pageCur;
    end
  end

  assign pageHit    = (pageReg == pageCur);
  assign wrAllow    = wrValid && (!protFlag || (ctl.winOpen && (!pageHeld || pageHit)));
  assign eraseAllow = eraseReq && !protFlag;
  assign protOn     = protFlag;

  // R3 / R10: protected writes outside a window never pass
  a_r3_blocked: assert property (@(posedge clk) disable iff (!rstN || !nvInitN)
    (protFlag && !ctl.winOpen) |-> !wrAllow);

  // R4: erase never passes while protected
  a_r4_erase_blocked: assert property (@(posedge clk) disable iff (!rstN || !nvInitN)
    protOn |-> !eraseAllow);

  // R5: a window only exists while protected
  a_r5_window_protected: assert property (@(posedge clk) disable iff (!rstN || !nvInitN)
    ctl.winOpen |-> protFlag);

  // R7: a completed clear code leaves the flag low
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rstN || !nvInitN)
    ctl.clrProt |=> !protOn);

  // R9: the flag moves only on a code strobe
  a_r9_flag_stable: assert property (@(posedge clk) disable iff (!nvInitN)
    (!ctl.setProt && !ctl.clrProt) |=> $stable(protOn));
endmodule

// File: rtl/wp_seq_top.sv
`timescale 1ns/1ps
module wp_seq_top
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int PAGE_LSB = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nvInitN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pageEnd,
  input  logic              eraseReq,
  output logic              wrAllow,
  output logic              eraseAllow,
  output logic              protOn
);
  keyHit_t    hit;
  ctlStrobe_t ctl;

  wp_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrValid (wrValid),
    .pageEnd (pageEnd),
    .hit     (hit),
    .ctl     (ctl)
  );

  wp_seq_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PAGE_LSB (PAGE_LSB)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .nvInitN    (nvInitN),
    .wrValid    (wrValid),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .eraseReq   (eraseReq),
    .ctl        (ctl),
    .hit        (hit),
    .wrAllow    (wrAllow),
    .eraseAllow (eraseAllow),
    .protOn     (protOn)
  );
endmodule

// File: tb/wp_seq_top_tb.sv
`timescale 1ns/1ps
module wp_seq_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        nvInitN = 1'b0;
  logic        wrValid = 1'b0;
  logic [10:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        pageEnd = 1'b0;
  logic        eraseReq = 1'b0;
  logic        wrAllow, eraseAllow, protOn;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  wp_seq_top u_dut (
    .clk(clk), .rstN(rstN), .nvInitN(nvInitN), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .pageEnd(pageEnd), .eraseReq(eraseReq),
    .wrAllow(wrAllow), .eraseAllow(eraseAllow), .protOn(protOn)
  );

  // monitor: compares each write's allow against the scoreboard
  always begin
    @(negedge clk);
    #5;
    if (wrValid) begin
      bit e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (wrAllow !== e) begin
        errors++;
        $display("FAIL %s: wrAllow=%0b expected %0b", t, wrAllow, e);
      end
    end
  end

  task automatic doWrite(input logic [10:0] a, input logic [7:0] d,
                         input bit e, input string t);
    @(negedge clk);
    wrAddr = a; wrData = d; wrValid = 1'b1;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic checkBit(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", t, act, e);
    end
  endtask

  task automatic checkErase(input logic e, input string t);
    @(negedge clk);
    eraseReq = 1'b1;
    #2 checkBit(eraseAllow, e, t);
    eraseReq = 1'b0;
  endtask

  task automatic pulseReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    nvInitN = 1'b1; rstN = 1'b1;
    @(negedge clk);
    checkBit(protOn, 1'b0, "R1 protOn after init");
    checkErase(1'b1, "R1 erase allowed unprotected");
    doWrite(11'h123, 8'h11, 1'b1, "R1 plain write unprotected");

    // set code while unprotected: writes committed
    doWrite(11'h555, 8'hAA, 1'b1, "R2 step1 committed");
    doWrite(11'h2AA, 8'h55, 1'b1, "R2 step2 committed");
    doWrite(11'h555, 8'hA0, 1'b1, "R2 step3 committed");
    @(negedge clk);
    checkBit(protOn, 1'b1, "R2 protOn set");
    doWrite(11'h0C0, 8'h11, 1'b1, "R5 first page byte");
    doWrite(11'h0C5, 8'h22, 1'b1, "R5 same page byte");
    doWrite(11'h100, 8'h33, 1'b0, "R5 other page blocked");
    doWrite(11'h0FF, 8'h34, 1'b1, "R5 last byte of page");
    @(negedge clk); pageEnd = 1'b1;
    @(negedge clk); pageEnd = 1'b0;
    doWrite(11'h0C0, 8'h44, 1'b0, "R6 write after page end");
    checkErase(1'b0, "R4 erase blocked");
    doWrite(11'h050, 8'h01, 1'b0, "R3 plain write protected");

    // protected, code accepted again opens a fresh window
    doWrite(11'h555, 8'hAA, 1'b0, "R10 step1 not committed");
    doWrite(11'h2AA, 8'h55, 1'b0, "R10 step2 not committed");
    doWrite(11'h555, 8'hA0, 1'b0, "R10 step3 not committed");
    doWrite(11'h200, 8'h66, 1'b1, "R5 new window allowed");
    @(negedge clk); pageEnd = 1'b1;
    @(negedge clk); pageEnd = 1'b0;

    // broken code
    doWrite(11'h555, 8'hAA, 1'b0, "R8 step1");
    doWrite(11'h2AA, 8'h55, 1'b0, "R8 step2");
    doWrite(11'h555, 8'h00, 1'b0, "R8 wrong step3");
    doWrite(11'h555, 8'hA0, 1'b0, "R8 lone final step");
    doWrite(11'h040, 8'h01, 1'b0, "R8 no window after break");

    // power-on reset keeps the flag and clears partial code
    pulseReset();
    checkBit(protOn, 1'b1, "R9 flag kept over reset");
    doWrite(11'h555, 8'hAA, 1'b0, "R9 step1");
    doWrite(11'h2AA, 8'h55, 1'b0, "R9 step2");
    pulseReset();
    doWrite(11'h555, 8'hA0, 1'b0, "R9 step3 after reset");
    doWrite(11'h040, 8'h02, 1'b0, "R9 no window after reset");

    // clear code
    doWrite(11'h555, 8'hAA, 1'b0, "R7 clr step1");
    doWrite(11'h2AA, 8'h55, 1'b0, "R7 clr step2");
    doWrite(11'h555, 8'h80, 1'b0, "R7 clr step3");
    doWrite(11'h555, 8'hAA, 1'b0, "R7 clr step4");
    doWrite(11'h2AA, 8'h55, 1'b0, "R7 clr step5");
    doWrite(11'h555, 8'h20, 1'b0, "R7 clr step6");
    @(negedge clk);
    checkBit(protOn, 1'b0, "R7 protOn cleared");
    doWrite(11'h040, 8'h05, 1'b1, "R7 write after clear");
    checkErase(1'b1, "R4 erase allowed after clear");

    repeat (3) @(negedge clk);
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finishRun();
    end
  end
endmodule